// File: doc/BRIEF.md
# Deduplicating Value-Shared Data Store

This block is the word-granular data array of a cache, built so that a wide value held by many words is stored only once. Each word owns a small pointer entry rather than a full data word. A wide value goes into a shared value table, and the word's entry holds the index of that table slot. A value that fits in a few bits skips the table: it is placed directly in the entry, and a flag bit marks the entry as inline.

Each table slot counts the words that refer to it. A slot whose count is zero is free. A wide write first looks for an existing slot holding the same value and shares it. When no slot holds the value, the write takes the lowest-numbered free slot. Overwriting a word drops its reference to the old slot in the same operation as the new write. A wide write that finds no match and no free slot is refused and has no effect. A one-cycle full pulse reports the refusal.

The read port returns the word one cycle after the request. An inline entry is restored to full width by sign extension.

Top module: `vds_store`

## Requirements
- R1: After reset, every word reads as zero, `rd_valid` is low and `full` is low.
- R2: When `rd_en` is high at a clock edge, `rd_valid` is high in the following cycle and `rd_data` holds the word at `rd_idx`. When `rd_en` is low, `rd_valid` is low in the following cycle. Reads in consecutive cycles return their words in request order.
- R3: A value is narrow when bits 31 down to 7 all equal bit 7. A narrow value reads back exactly as written, that is, sign-extended from its low 8 bits. A narrow write is always accepted, even when the value table has no free slot.
- R4: A wide value reads back exactly as written. This includes the values just outside the narrow range, 0x00000080 and 0xFFFFFF7F.
- R5: A wide value already held in the table is shared. Writing it to another word is accepted even when every slot is in use.
- R6: A slot is freed only when no word refers to it any longer. While one word still holds the value, the slot stays occupied.
- R7: When a write overwrites the only word that refers to a slot, that slot's release counts as part of the same write. A new distinct wide value is therefore accepted even when the table was full before the write.
- R8: A wide write with no matching slot and no free slot leaves the word unchanged. `full` is high in the cycle after that write.
- R9: A read and a write to the same word in the same cycle return the value held before the write.
- R10: `full` is low in the cycle after any accepted write and in the cycle after any cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 7 | Word index for the write |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Read request |
| rd_idx | input | 7 | Word index for the read |
| rd_data | output | 32 | Read value, registered |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| full | output | 1 | Pulse: the previous write was refused |

## Verification
Both results are due exactly one clock edge after their request. The read word and its valid flag appear in the cycle after `rd_en`. The full pulse appears in the cycle after the write it reports on. The bench drives inputs on the falling edge and queues the expected read value when it issues each request. A monitor compares the value on the next falling edge, and the write task checks `full` on that same following falling edge. Whether a write is accepted is predicted from a word-level model: the bench counts the distinct wide values held by the other words and checks whether the new value is among them. This prediction uses no knowledge of slot numbering.

// File: rtl/vds_pkg.sv
package vds_pkg;

   // width of the per-word field that holds either an inline value or a slot index
   localparam int unsigned ENTRY_FLD_W = 8;

   typedef struct packed {
      logic                   inl;   // 1: fld is an inline narrow value
      logic [ENTRY_FLD_W-1:0] fld;
   } ptr_entry_t;

   localparam ptr_entry_t ENTRY_RESET = '{inl: 1'b1, fld: '0};

endpackage

// File: rtl/vds_narrow_cls.sv
module vds_narrow_cls #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FLD_W     = 8,
   parameter bit          INLINE_EN = 1'b1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              narrow_o,
   output logic [FLD_W-1:0]  code_o
);

   if (DATA_W <= FLD_W) begin : g_bad_width
      $error("vds_narrow_cls: DATA_W must exceed FLD_W");
   end

   localparam int unsigned HI_W = DATA_W - FLD_W + 1;

   logic [HI_W-1:0] upper;
   assign upper  = data_i[DATA_W-1:FLD_W-1];
   assign code_o = data_i[FLD_W-1:0];

   if (INLINE_EN) begin : g_inline
      assign narrow_o = (&upper) | ~(|upper);
   end else begin : g_no_inline
      assign narrow_o = 1'b0;
   end

endmodule

// File: rtl/vds_ptr_table.sv
module vds_ptr_table #(
   parameter  int unsigned NUM_WORDS = 128,
   localparam int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [IDX_W-1:0]    widx_i,
   input  vds_pkg::ptr_entry_t wentry_i,
   output vds_pkg::ptr_entry_t old_o,
   input  logic [IDX_W-1:0]    ridx_i,
   output vds_pkg::ptr_entry_t rentry_o
);

   if (NUM_WORDS < 2) begin : g_bad_depth
      $error("vds_ptr_table: NUM_WORDS must be at least 2");
   end

   vds_pkg::ptr_entry_t ent_q [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[w] <= vds_pkg::ENTRY_RESET;
         end else if (we_i && (widx_i == IDX_W'(w))) begin
            ent_q[w] <= wentry_i;
         end
      end
   end

   assign old_o    = ent_q[widx_i];
   assign rentry_o = ent_q[ridx_i];

endmodule

// File: rtl/vds_value_table.sv
module vds_value_table #(
   parameter  int unsigned DATA_W    = 32,
   parameter  int unsigned VT_DEPTH  = 64,
   parameter  int unsigned NUM_WORDS = 128,
   localparam int unsigned SLOT_W    = $clog2(VT_DEPTH),
   localparam int unsigned CNT_W     = $clog2(NUM_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic              need_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              rel_en_i,
   input  logic [SLOT_W-1:0] rel_slot_i,
   output logic [SLOT_W-1:0] slot_o,
   output logic              refuse_o,
   input  logic [SLOT_W-1:0] rd_slot_i,
   output logic [DATA_W-1:0] rd_word_o
);

   if (VT_DEPTH < 2 || (1 << SLOT_W) != VT_DEPTH) begin : g_bad_depth
      $error("vds_value_table: VT_DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] data_q  [VT_DEPTH];
   logic [CNT_W-1:0]  cnt_q   [VT_DEPTH];
   logic [CNT_W-1:0]  cnt_eff [VT_DEPTH];
   logic [VT_DEPTH-1:0] match_vec, free_vec;
   logic [SLOT_W-1:0]   match_idx, free_idx;
   logic                hit, any_free;

   for (genvar g = 0; g < VT_DEPTH; g++) begin : g_slot
      assign match_vec[g] = (cnt_q[g] != '0) && (data_q[g] == val_i);
      assign cnt_eff[g]   = cnt_q[g] - CNT_W'(rel_en_i && (rel_slot_i == SLOT_W'(g)));
      assign free_vec[g]  = (cnt_eff[g] == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q[g]  <= '0;
            data_q[g] <= '0;
         end else if (commit_i) begin
            cnt_q[g] <= cnt_eff[g] + CNT_W'(need_i && (slot_o == SLOT_W'(g)));
            if (need_i && !hit && (free_idx == SLOT_W'(g))) begin
               data_q[g] <= val_i;
            end
         end
      end

      // a refused or absent write leaves every count untouched
      a_r8_count_hold : assert property (@(posedge clk) disable iff (!rst_n)
         !commit_i |=> $stable(cnt_q[g]));
      // R6: no slot is ever referenced by more words than exist
      a_r6_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q[g] <= CNT_W'(NUM_WORDS));
   end

   always_comb begin
      match_idx = '0;
      free_idx  = '0;
      for (int i = VT_DEPTH - 1; i >= 0; i--) begin
         if (match_vec[i]) match_idx = SLOT_W'(i);
         if (free_vec[i])  free_idx  = SLOT_W'(i);
      end
   end

   assign hit       = |match_vec;
   assign any_free  = |free_vec;
   assign refuse_o  = need_i && !hit && !any_free;
   assign slot_o    = hit ? match_idx : free_idx;
   assign rd_word_o = data_q[rd_slot_i];

   // R5: a value lives in at most one slot
   a_r5_single_copy : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
   // R6: a released slot must have been live
   a_r6_release_live : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && rel_en_i) |-> (cnt_q[rel_slot_i] != '0));

endmodule

// File: rtl/vds_store.sv
module vds_store #(
   parameter  int unsigned DATA_W    = 32,
   parameter  int unsigned NUM_WORDS = 128,
   parameter  int unsigned VT_DEPTH  = 64,
   parameter  bit          INLINE_EN = 1'b1,
   localparam int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              full
);

   localparam int unsigned FLD_W  = vds_pkg::ENTRY_FLD_W;
   localparam int unsigned SLOT_W = $clog2(VT_DEPTH);

   if (SLOT_W > FLD_W) begin : g_bad_slot
      $error("vds_store: slot index does not fit the entry field");
   end
   if (DATA_W <= FLD_W) begin : g_bad_data
      $error("vds_store: DATA_W must exceed the entry field width");
   end

   logic                narrow;
   logic [FLD_W-1:0]    code;
   vds_pkg::ptr_entry_t old_ent, new_ent, rd_ent;
   logic [SLOT_W-1:0]   slot;
   logic                refuse, commit, need;
   logic [DATA_W-1:0]   vt_word, rd_word;
   logic [DATA_W-1:0]   rd_data_q;
   logic                rd_valid_q, full_q;

   vds_narrow_cls #(
      .DATA_W   (DATA_W),
      .FLD_W    (FLD_W),
      .INLINE_EN(INLINE_EN)
   ) u_cls (
      .data_i  (wr_data),
      .narrow_o(narrow),
      .code_o  (code)
   );

   assign need    = wr_en && !narrow;
   assign commit  = wr_en && !refuse;
   assign new_ent = narrow ? '{inl: 1'b1, fld: code}
                           : '{inl: 1'b0, fld: FLD_W'(slot)};

   vds_ptr_table #(
      .NUM_WORDS(NUM_WORDS)
   ) u_ptab (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (commit),
      .widx_i  (wr_idx),
      .wentry_i(new_ent),
      .old_o   (old_ent),
      .ridx_i  (rd_idx),
      .rentry_o(rd_ent)
   );

   vds_value_table #(
      .DATA_W   (DATA_W),
      .VT_DEPTH (VT_DEPTH),
      .NUM_WORDS(NUM_WORDS)
   ) u_vtab (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit),
      .need_i    (need),
      .val_i     (wr_data),
      .rel_en_i  (!old_ent.inl),
      .rel_slot_i(old_ent.fld[SLOT_W-1:0]),
      .slot_o    (slot),
      .refuse_o  (refuse),
      .rd_slot_i (rd_ent.fld[SLOT_W-1:0]),
      .rd_word_o (vt_word)
   );

   assign rd_word = rd_ent.inl ? {{(DATA_W-FLD_W){rd_ent.fld[FLD_W-1]}}, rd_ent.fld}
                               : vt_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
         full_q     <= 1'b0;
      end else begin
         rd_valid_q <= rd_en;
         full_q     <= wr_en && refuse;
         if (rd_en) rd_data_q <= rd_word;
      end
   end

   assign rd_data  = rd_data_q;
   assign rd_valid = rd_valid_q;
   assign full     = full_q;

   a_r2_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r2_valid_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   a_r8_full_on_refuse : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && refuse) |=> full);
   a_r10_full_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !full);
   a_r3_narrow_accepted : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && narrow) |=> !full);

endmodule

// File: tb/tb_vds_store.sv
`timescale 1ns/1ps
module tb_vds_store;

   localparam int DW = 32;
   localparam int NW = 128;
   localparam int VD = 64;
   localparam int IW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [IW-1:0] wr_idx = '0, rd_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid, full;

   vds_store dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid), .full(full)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] model [NW];
   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit is_narrow(input logic [DW-1:0] v);
      return (v[31:7] == '0) || (&v[31:7]);
   endfunction

   // accepted unless wide, new, and the other words already hold VD distinct wide values
   function automatic bit pred_full(input int idx, input logic [DW-1:0] v);
      logic [DW-1:0] seen [$];
      if (is_narrow(v)) return 1'b0;
      for (int w = 0; w < NW; w++) begin
         if (w == idx || is_narrow(model[w])) continue;
         if (model[w] == v) return 1'b0;
         if (!(model[w] inside {seen})) seen.push_back(model[w]);
      end
      return seen.size() >= VD;
   endfunction

   task automatic wr(input int idx, input logic [DW-1:0] v, input string req);
      bit ef;
      ef = pred_full(idx, v);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      check(full == ef, req, {31'b0, full}, {31'b0, ef});
      if (!ef) model[idx] = v;
   endtask

   task automatic rd(input int idx, input string req);
      exp_q.push_back(model[idx]); tag_q.push_back(req);
      rd_en = 1'b1; rd_idx = IW'(idx);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // R9: read and write the same word in one cycle
   task automatic rd_wr_same(input int idx, input logic [DW-1:0] v);
      exp_q.push_back(model[idx]); tag_q.push_back("R9");
      rd_en = 1'b1; rd_idx = IW'(idx);
      wr(idx, v, "R9");
      rd_en = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", {31'b0, rd_valid}, '0);
         end else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rd_data == e, t, rd_data, e);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", '0, '0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int w = 0; w < NW; w++) model[w] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      check(full == 1'b0, "R1", {31'b0, full}, '0);
      check(rd_valid == 1'b0, "R1", {31'b0, rd_valid}, '0);
      rd(0, "R1"); rd(77, "R1"); rd(127, "R1");

      // R3: narrow values at and inside the boundary
      wr(1, 32'h0000_0005, "R3"); wr(4, 32'hFFFF_FFFD, "R3");
      wr(5, 32'h0000_007F, "R3"); wr(6, 32'hFFFF_FF80, "R3");
      rd(1, "R3"); rd(4, "R3"); rd(5, "R3"); rd(6, "R3");

      // R4: just outside the narrow range, and an ordinary wide value
      wr(2, 32'h0000_0080, "R4"); wr(3, 32'hFFFF_FF7F, "R4");
      wr(10, 32'hDEAD_BEEF, "R4"); wr(11, 32'hDEAD_BEEF, "R5");
      rd(2, "R4"); rd(3, "R4"); rd(10, "R4"); rd(11, "R5");

      // fill the value table past its capacity; the model predicts every refusal
      for (int i = 0; i < 70; i++) wr(40 + i, 32'hA500_0000 + i, "R8");

      // R2: back-to-back reads in request order
      rd_en = 1'b1;
      for (int k = 40; k < 52; k++) begin
         exp_q.push_back(model[k]); tag_q.push_back("R2");
         rd_idx = IW'(k);
         @(negedge clk);
      end
      rd_en = 1'b0;
      @(negedge clk);

      // R8: a new wide value with the table full is refused and leaves the word
      wr(120, 32'h1234_5678, "R8"); rd(120, "R8");
      // R10: a following quiet cycle drops full
      @(negedge clk);
      check(full == 1'b0, "R10", {31'b0, full}, '0);
      // R5: an existing value is shared while full
      wr(121, 32'hA500_0005, "R5"); rd(121, "R5");
      // R3: narrow writes still succeed while full
      wr(122, 32'hFFFF_FF90, "R3"); rd(122, "R3");

      // R6: releasing one of two references keeps the slot occupied
      wr(10, 32'h0000_0001, "R6");
      wr(120, 32'h1234_5678, "R6"); rd(120, "R6");
      wr(11, 32'h0000_0002, "R6");
      wr(120, 32'h1234_5678, "R6"); rd(120, "R6");

      // R7: overwriting a sole reference frees its slot within the same write
      wr(40, 32'h7777_7777, "R7"); rd(40, "R7");
      wr(41, 32'hA500_0000, "R7"); rd(41, "R7");

      // R9: same-cycle read and write return the old value
      rd_wr_same(120, 32'h0000_0003);
      rd(120, "R9");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2", exp_q.size(), '0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule